// File: doc/BRIEF.md
# Split-Tag Address Translation Cache

This block caches virtual-to-physical page translations for a core's fetch, load and store accesses. It is direct-mapped: the low bits of the virtual page number select an entry. Each entry holds one physical page number, shared by all three access kinds, and three independent virtual tags, one per kind. A translation can therefore be usable for loads while fetches or stores to the same page still miss and take the slow path.

A request strobe carries a virtual address, an access kind and an access size. One cycle later the block reports whether the access hit, was misaligned, or needs a debug trigger check, together with the physical address. A refill port installs a page number and one kind's tag, and can set a per-tag trigger flag. A tag with this flag set still hits, but the access must be shown to external trigger comparators first. In that response cycle the block takes the comparator's verdict. It then either aborts the access or records the first deferred match until software clears it. A flush input invalidates every tag at once.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `rsp_valid` and `rec_valid` are low and every lookup of every kind misses.
- R2: A request sampled at a clock edge gives `rsp_valid` high for exactly the following cycle. The lookup sees the tag state from before any refill or flush sampled at the same edge.
- R3: Kind encoding is 0 fetch, 1 load, 2 store, and 3 reserved (always misses). An access hits when the kind's tag at index `vpn mod ENTRIES` is valid and equals the whole virtual page number (`vaddr[VA_W-1:12]`). On a hit, `rsp_paddr` is the entry's page number concatenated with `vaddr[11:0]`.
- R4: Each kind's tag is written only by a refill of that kind. The physical page number is shared, and a refill of any kind replaces it for the entry.
- R5: A page whose number maps to an occupied index but differs from the stored tag misses. A refill at that index displaces the old tag.
- R6: A hit on a tag refilled with the trigger flag reports `rsp_trig` high. A hit on an unflagged tag reports it low.
- R7: A load or store is misaligned when `vaddr[2:0]` ANDed with `(1<<size)-1` is nonzero. Here `size` is log2 of the byte count, 0 to 3. A misaligned access reports `rsp_misalign` high with `rsp_hit` and `rsp_trig` low. Fetches are never misaligned.
- R8: `flush` invalidates every tag of every kind. It takes precedence over a refill in the same cycle.
- R9: In a response cycle with `rsp_trig` and `trig_match` high, `rsp_abort` is high for a fetch, and for a load or store when `trig_late` is low. In every other case it is low.
- R10: A load or store with `rsp_trig`, `trig_match` and `trig_late` high, while nothing is recorded, sets `rec_valid` with its virtual address and `rec_store` (1 for a store). Later matches leave the record unchanged. `trig_clear` clears it and wins over a simultaneous match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all tags |
| req_valid | input | 1 | Lookup strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_size | input | 2 | log2 of the access size in bytes |
| fill_valid | input | 1 | Refill strobe |
| fill_kind | input | 2 | Kind whose tag is written |
| fill_vpn | input | VA_W-PG_SHIFT | Virtual page number for the tag |
| fill_ppn | input | PA_W-PG_SHIFT | Physical page number for the entry |
| fill_trig | input | 1 | Set the trigger-check flag on the written tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_trig | output | 1 | Hit needs a trigger check |
| rsp_misalign | output | 1 | Access diverted as misaligned |
| rsp_paddr | output | PA_W | Physical address on a hit |
| trig_match | input | 1 | Comparator verdict for the current response |
| trig_late | input | 1 | Matched trigger fires after the access completes |
| trig_clear | input | 1 | Clear the recorded match |
| rsp_abort | output | 1 | Access must be aborted with a trigger exception |
| rec_valid | output | 1 | A deferred match is recorded |
| rec_store | output | 1 | Recorded access was a store |
| rec_vaddr | output | VA_W | Virtual address of the recorded access |

## Verification
The hardest situation to reach from the ports is a deferred trigger match that must survive later matches. The bench first refills a flagged tag. A flagged load with a late match then creates the record. A second flagged tag of another kind is refilled at the same index, and a flagged store with a late match must leave the first record alone. Only after `trig_clear` does the store get recorded. The bench also drives a request and a refill to the same entry in one cycle. It checks that the response shows the old state and that the next lookup shows the new one. A flush in the same cycle as a refill must leave the entry empty.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 56,
  parameter int PG_SHIFT = 12,
  parameter int ENTRIES  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [1:0]               req_size,
  input  logic                     fill_valid,
  input  logic [1:0]               fill_kind,
  input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
  input  logic                     fill_trig,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_trig,
  output logic                     rsp_misalign,
  output logic [PA_W-1:0]          rsp_paddr,
  input  logic                     trig_match,
  input  logic                     trig_late,
  input  logic                     trig_clear,
  output logic                     rsp_abort,
  output logic                     rec_valid,
  output logic                     rec_store,
  output logic [VA_W-1:0]          rec_vaddr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  logic [VPN_W-1:0]   tag_q [3][ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q [3];
  logic [ENTRIES-1:0] flg_q [3];

  logic [1:0]      rsp_kind;
  logic [VA_W-1:0] rsp_vaddr;

  wire [VPN_W-1:0] req_vpn  = req_vaddr[VA_W-1:PG_SHIFT];
  wire [IDX_W-1:0] req_idx  = req_vpn[IDX_W-1:0];
  wire [IDX_W-1:0] fill_idx = fill_vpn[IDX_W-1:0];
  wire             kind_ok  = req_kind != 2'd3;
  wire [1:0]       kidx     = kind_ok ? req_kind : 2'd0;
  wire [2:0]       lo_mask  = 3'((4'd1 << req_size) - 4'd1);
  wire             mis      = (req_kind == 2'd1 || req_kind == 2'd2) && ((req_vaddr[2:0] & lo_mask) != 3'd0);
  wire             lk_hit   = kind_ok && !mis && vld_q[kidx][req_idx] && (tag_q[kidx][req_idx] == req_vpn);
  wire             lk_trig  = lk_hit && flg_q[kidx][req_idx];

  always_ff @(posedge clk) begin
    if (fill_valid && fill_kind != 2'd3) begin
      tag_q[fill_kind][fill_idx] <= fill_vpn;
      ppn_q[fill_idx]            <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n || flush) begin
        vld_q[k] <= '0;
        flg_q[k] <= '0;
      end else if (fill_valid && fill_kind == 2'(k)) begin
        vld_q[k][fill_idx] <= 1'b1;
        flg_q[k][fill_idx] <= fill_trig;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_trig     <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_paddr    <= '0;
      rsp_kind     <= 2'd0;
      rsp_vaddr    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= lk_hit;
        rsp_trig     <= lk_trig;
        rsp_misalign <= mis;
        rsp_paddr    <= {ppn_q[req_idx], req_vaddr[PG_SHIFT-1:0]};
        rsp_kind     <= req_kind;
        rsp_vaddr    <= req_vaddr;
      end
    end
  end

  wire fire    = rsp_valid && rsp_trig && trig_match;
  assign rsp_abort = fire && (rsp_kind == 2'd0 || !trig_late);
  wire rec_set = fire && rsp_kind != 2'd0 && trig_late && !rec_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || trig_clear) begin
      rec_valid <= 1'b0;
      rec_store <= 1'b0;
      rec_vaddr <= '0;
    end else if (rec_set) begin
      rec_valid <= 1'b1;
      rec_store <= rsp_kind == 2'd2;
      rec_vaddr <= rsp_vaddr;
    end
  end

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[PG_SHIFT-1:0] == $past(req_vaddr[PG_SHIFT-1:0])));
  a_r6_trig_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trig |-> rsp_hit && !rsp_misalign);
  a_r7_misalign_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misalign |-> !rsp_hit);
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && req_valid |=> !rsp_hit);
  a_r9_abort_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |=> !$rose(rec_valid));
  a_r10_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !trig_clear |=> rec_valid && $stable(rec_vaddr) && $stable(rec_store));
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int VA_W = 32, PA_W = 24, PG = 12, E = 8;
  localparam int VPN_W = VA_W - PG, PPN_W = PA_W - PG;

  logic clk = 0, rst_n = 0, flush = 0;
  logic req_valid = 0; logic [1:0] req_kind = 0; logic [VA_W-1:0] req_vaddr = 0; logic [1:0] req_size = 0;
  logic fill_valid = 0; logic [1:0] fill_kind = 0; logic [VPN_W-1:0] fill_vpn = 0;
  logic [PPN_W-1:0] fill_ppn = 0; logic fill_trig = 0;
  logic trig_match = 0, trig_late = 0, trig_clear = 0;
  logic rsp_valid, rsp_hit, rsp_trig, rsp_misalign, rsp_abort, rec_valid, rec_store;
  logic [PA_W-1:0] rsp_paddr; logic [VA_W-1:0] rec_vaddr;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG), .ENTRIES(E)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [VPN_W-1:0] m_tag [3][E];
  bit m_vld [3][E], m_flg [3][E];
  logic [PPN_W-1:0] m_ppn [E];
  bit m_rec = 0, m_rec_st = 0; logic [VA_W-1:0] m_rec_va = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va_of(input int hi, input int idx, input int off);
    return VA_W'(((hi * E + idx) << PG) + off);
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 3; k++) for (int i = 0; i < E; i++) begin m_vld[k][i] = 0; m_flg[k][i] = 0; end
  endtask

  task automatic do_fill(input int k, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn, input bit trg);
    @(negedge clk);
    fill_valid = 1; fill_kind = 2'(k); fill_vpn = vpn; fill_ppn = ppn; fill_trig = trg;
    @(negedge clk);
    fill_valid = 0;
    if (k != 3) begin
      m_tag[k][vpn % E] = vpn; m_ppn[vpn % E] = ppn;
      m_vld[k][vpn % E] = 1; m_flg[k][vpn % E] = trg;
    end
  endtask

  task automatic lookup(input int k, input logic [VA_W-1:0] va, input int sz,
                        input bit tm, input bit tl, input string rq);
    logic [VPN_W-1:0] vpn; int idx; bit mis, hit, trg, ab;
    vpn = va[VA_W-1:PG]; idx = int'(vpn % E);
    mis = (k == 1 || k == 2) && ((va[2:0] & 3'((1 << sz) - 1)) != 0);
    hit = (k != 3) && !mis && m_vld[k % 3][idx] && m_tag[k % 3][idx] == vpn;
    trg = hit && m_flg[k % 3][idx];
    ab  = trg && tm && (k == 0 || !tl);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_vaddr = va; req_size = 2'(sz);
    @(negedge clk);
    req_valid = 0; trig_match = tm; trig_late = tl;
    #1;
    chk(rq, "valid", rsp_valid, 1);
    chk(rq, "hit", rsp_hit, hit);
    chk(rq, "misalign", rsp_misalign, mis);
    chk(rq, "trig", rsp_trig, trg);
    if (hit) chk(rq, "paddr", rsp_paddr, {m_ppn[idx], va[PG-1:0]});
    chk(rq, "abort", rsp_abort, ab);
    @(negedge clk);
    trig_match = 0; trig_late = 0;
    if (trg && tm && tl && k != 0 && !m_rec) begin m_rec = 1; m_rec_va = va; m_rec_st = (k == 2); end
  endtask

  task automatic chk_rec(input string rq);
    chk(rq, "rec_valid", rec_valid, m_rec);
    if (m_rec) begin
      chk(rq, "rec_vaddr", rec_vaddr, m_rec_va);
      chk(rq, "rec_store", rec_store, m_rec_st);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "rec_valid", rec_valid, 0);
    for (int k = 0; k < 3; k++) for (int i = 0; i < E; i++) lookup(k, va_of(0, i, 0), 0, 0, 0, "R1");

    for (int i = 0; i < E; i++) for (int k = 0; k < 3; k++)
      do_fill(k, VPN_W'((k + 1) * E + i), PPN_W'(i * 16 + k + 1), (i == 5 && k == 1) || (i == 6 && k == 0));
    for (int k = 0; k < 3; k++) for (int i = 0; i < E; i++) for (int q = 0; q < 3; q++)
      lookup(k, va_of(q + 1, i, (i * 37 + q * 8) % 4096), 3, 0, 0, "R4");
    for (int i = 0; i < E; i++) lookup(i % 3, va_of(7, i, 0), 0, 0, 0, "R5");
    do_fill(1, VPN_W'(7 * E + 3), 12'hABC, 0);
    lookup(1, va_of(7, 3, 16), 2, 0, 0, "R5");
    lookup(1, va_of(2, 3, 16), 2, 0, 0, "R5");
    lookup(0, va_of(1, 3, 4), 0, 0, 0, "R4");
    lookup(3, va_of(1, 2, 0), 0, 0, 0, "R3");
    lookup(1, va_of(2, 5, 8), 3, 0, 0, "R6");
    lookup(1, va_of(2, 4, 8), 3, 0, 0, "R6");

    for (int k = 0; k < 3; k++) for (int sz = 0; sz < 4; sz++) for (int off = 0; off < 8; off++)
      lookup(k, va_of(k + 1, 1, 64 + off), sz, 0, 0, "R7");

    lookup(1, va_of(2, 5, 0), 2, 1, 0, "R9");
    chk_rec("R9");
    lookup(1, va_of(2, 5, 4), 2, 0, 1, "R9");
    lookup(1, va_of(2, 5, 12), 2, 1, 1, "R10");
    chk_rec("R10");
    lookup(0, va_of(1, 6, 2), 0, 1, 1, "R9");
    do_fill(2, VPN_W'(3 * E + 5), 12'h055, 1);
    lookup(2, va_of(3, 5, 32), 3, 1, 1, "R10");
    chk_rec("R10");
    @(negedge clk); trig_clear = 1;
    @(negedge clk); trig_clear = 0; m_rec = 0;
    chk_rec("R10");
    lookup(2, va_of(3, 5, 40), 3, 1, 1, "R10");
    chk_rec("R10");
    @(negedge clk); trig_clear = 1; req_valid = 1; req_kind = 2'd1; req_vaddr = va_of(2, 5, 0); req_size = 0;
    @(negedge clk); trig_clear = 0; req_valid = 0; trig_match = 1; trig_late = 1; m_rec = 0;
    @(negedge clk); trig_match = 0; trig_late = 0; m_rec = 1; m_rec_va = va_of(2, 5, 0); m_rec_st = 0;
    chk_rec("R10");

    @(negedge clk);
    req_valid = 1; req_kind = 2'd1; req_vaddr = va_of(6, 2, 0); req_size = 0;
    fill_valid = 1; fill_kind = 2'd1; fill_vpn = VPN_W'(6 * E + 2); fill_ppn = 12'h777; fill_trig = 0;
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    #1;
    chk("R2", "rsp_valid", rsp_valid, 1);
    chk("R2", "hit_old_state", rsp_hit, 0);
    @(negedge clk); #1;
    chk("R2", "rsp_valid_drop", rsp_valid, 0);
    m_tag[1][2] = VPN_W'(6 * E + 2); m_ppn[2] = 12'h777; m_vld[1][2] = 1; m_flg[1][2] = 0;
    lookup(1, va_of(6, 2, 12), 2, 0, 0, "R2");

    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0; clear_model();
    for (int k = 0; k < 3; k++) for (int i = 0; i < E; i++) lookup(k, va_of(k + 1, i, 0), 0, 0, 0, "R8");
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_kind = 2'd0; fill_vpn = VPN_W'(E + 4); fill_ppn = 12'h123; fill_trig = 0;
    @(negedge clk); flush = 0; fill_valid = 0;
    lookup(0, va_of(1, 4, 0), 0, 0, 0, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule